// File: doc/BRIEF.md
# Dual Byte Stack Unit

This block holds two byte-wide last-in-first-out stacks for a small stack-machine datapath: a working stack and a return stack. Each has its own 8-bit pointer that counts the bytes it holds. On each cycle one stack operation can be presented. The operation carries a stack select, a keep flag, a flip flag, a count of bytes consumed and a signed net pointer change. It also carries up to three items to push, as bytes or as 16-bit words. The unit checks the operation against the bounds of the stack and moves the pointer. It then writes the pushed bytes below the new top.

The datapath reads its operands from combinational taps. These give the top three bytes and the top three 16-bit words of the selected stack, as it stands before the operation. In keep mode the consumed bytes are left in place, so the results are pushed above the operands. A flip sends the pushed data to the opposite stack. This serves subroutine calls and stash moves, and the destination stack gets its own bounds check. A fault is reported as a one-cycle strobe with a 2-bit code. On a fault cycle nothing in the unit changes.

Top module: `dual_byte_stack`

## Requirements
- R1: Synchronous active-high reset sets both pointers to 0 and holds `fault_valid` low.
- R2: `op_rsel` = 1 selects the return stack and 0 the working stack, for both the operation and the taps. Without a flip, the other stack's pointer and contents do not change.
- R3: When keep is clear, a successful operation sets the selected pointer to old pointer + `op_net` (signed, two's complement).
- R4: When keep is set, a successful operation sets the selected pointer to old pointer + `op_pop` + `op_net`. The consumed bytes remain readable below the pushed results.
- R5: If `op_pop` exceeds the selected pointer, fault code 1 is reported. Neither pointer nor any stored byte changes.
- R6: If the computed source pointer exceeds 254, fault code 2 is reported. Neither pointer nor any stored byte changes.
- R7: In byte mode (`wr_word` = 0), item k (the low byte of `wr_data[16k+15:16k]`, with k below `wr_cnt`) is written at position newtop-1-k.
- R8: In word mode (`wr_word` = 1), item k is written with its low byte at newtop-1-2k and its high byte at newtop-2-2k. A single word therefore puts its low byte on top.
- R9: With P as the selected pointer and B(i) as the byte at position (P-1-i) mod 256: `tap_t`=B0, `tap_n`=B1, `tap_l`=B2, `tap_t2`={B1,B0}, `tap_n2`={B3,B2} and `tap_l2`={B5,B4}.
- R10: With `op_flip` = 1, the selected stack's pointer is updated by the R3/R4 rule. The pushed bytes go to the opposite stack, whose pointer grows by the pushed byte count (`wr_cnt`, or twice that in word mode).
- R11: With `op_flip` = 1, if the opposite stack's new pointer would exceed 254, fault code 2 is reported and both stacks stay unchanged.
- R12: `fault_valid` is high only in the cycle after a faulting operation. `op_valid` = 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An operation is presented this cycle |
| op_rsel | input | 1 | 1 = return stack, 0 = working stack; also picks the taps |
| op_keep | input | 1 | Keep operands (consumed count added back) |
| op_flip | input | 1 | Push to the opposite stack |
| op_pop | input | 3 | Bytes the operation consumes |
| op_net | input | 4 | Signed net change of the selected pointer |
| wr_word | input | 1 | 1 = items are 16-bit words, 0 = bytes |
| wr_cnt | input | 2 | Number of items to push (0 to 3) |
| wr_data | input | 48 | Items; item k in bits 16k+15:16k |
| tap_t | output | 8 | Top byte |
| tap_n | output | 8 | Second byte |
| tap_l | output | 8 | Third byte |
| tap_t2 | output | 16 | Top word |
| tap_n2 | output | 16 | Second word |
| tap_l2 | output | 16 | Third word |
| wst_ptr | output | 8 | Working stack pointer |
| rst_ptr | output | 8 | Return stack pointer |
| fault_valid | output | 1 | Fault strobe |
| fault_code | output | 2 | 1 = underflow, 2 = overflow |

## Verification
The underflow check is swept over every consumed count from 0 to 7 against every pointer from 0 to 6 on both stacks. This separates a strict from a non-strict comparison and shows that the stacks are kept apart. At the top of the range, each net change is tried at every pointer from about 248 up to 254, with keep set and with keep clear. This pins the limit at exactly 254 and shows that the consumed count is added only in keep mode. Byte pushes and word pushes of one to three items confirm the byte order and the slot offsets. Flip operations run toward a nearly full stack and toward a roomy one, and a long pseudo-random mix of all fields exercises the combinations.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_UNDER = 2'd1,
      FLT_OVER  = 2'd2
   } fault_e;

   localparam int NUM_STACKS = 2;
   localparam int TAP_BYTES  = 6;
endpackage

// File: rtl/dbs_bounds.sv
// Pointer arithmetic and bounds check for one stack.
module dbs_bounds #(
   parameter int PTR_W = 8,
   parameter int POP_W = 3,
   parameter int NET_W = 4
) (
   input  logic [PTR_W-1:0] ptr_i,
   input  logic [POP_W-1:0] take_i,
   input  logic             keep_i,
   input  logic [NET_W-1:0] delta_i,
   output logic [PTR_W-1:0] next_o,
   output logic             under_o,
   output logic             over_o
);
   localparam int MAXW = (PTR_W > NET_W) ? ((PTR_W > POP_W) ? PTR_W : POP_W)
                                         : ((NET_W > POP_W) ? NET_W : POP_W);
   localparam int SW = MAXW + 2;
   localparam logic signed [SW-1:0] LIMIT = SW'((1 << PTR_W) - 2);

   logic signed [SW-1:0] base_s;
   logic signed [SW-1:0] take_raw;
   logic signed [SW-1:0] take_s;
   logic signed [SW-1:0] delta_s;
   logic signed [SW-1:0] sum_s;

   always_comb begin
      base_s   = $signed({{(SW-PTR_W){1'b0}}, ptr_i});
      take_raw = $signed({{(SW-POP_W){1'b0}}, take_i});
      take_s   = keep_i ? take_raw : '0;
      delta_s  = $signed({{(SW-NET_W){delta_i[NET_W-1]}}, delta_i});
      sum_s    = base_s + take_s + delta_s;
      under_o  = take_raw > base_s;
      over_o   = sum_s > LIMIT;
      next_o   = sum_s[PTR_W-1:0];
   end
endmodule

// File: rtl/dbs_pack.sv
// Spreads pushed items over byte slots in byte or word order.
module dbs_pack #(
   parameter int DATA_W = 8,
   parameter int ITEMS  = 3,
   parameter int CNT_W  = 2,
   parameter int NB_W   = 3
) (
   input  logic                        word_i,
   input  logic [CNT_W-1:0]            cnt_i,
   input  logic [ITEMS*2*DATA_W-1:0]   items_i,
   output logic [ITEMS*2*DATA_W-1:0]   slots_o,
   output logic [2*ITEMS-1:0]          mask_o,
   output logic [NB_W-1:0]             nbytes_o
);
   localparam int IW = 2 * DATA_W;

   always_comb begin
      slots_o = '0;
      mask_o  = '0;
      if (word_i) begin
         for (int i = 0; i < ITEMS; i++) begin
            slots_o[(2*i)*DATA_W +: DATA_W]   = items_i[i*IW +: DATA_W];
            slots_o[(2*i+1)*DATA_W +: DATA_W] = items_i[i*IW+DATA_W +: DATA_W];
            mask_o[2*i]   = i < int'(cnt_i);
            mask_o[2*i+1] = i < int'(cnt_i);
         end
         nbytes_o = NB_W'({cnt_i, 1'b0});
      end else begin
         for (int i = 0; i < ITEMS; i++) begin
            slots_o[i*DATA_W +: DATA_W] = items_i[i*IW +: DATA_W];
            mask_o[i] = i < int'(cnt_i);
         end
         nbytes_o = NB_W'(cnt_i);
      end
   end
endmodule

// File: rtl/dbs_bank.sv
// Storage for one stack: multi-byte write below a top, fixed read taps.
module dbs_bank #(
   parameter int PTR_W  = 8,
   parameter int DATA_W = 8,
   parameter int SLOTS  = 6
) (
   input  logic                     clk,
   input  logic                     we_i,
   input  logic [PTR_W-1:0]         top_i,
   input  logic [SLOTS*DATA_W-1:0]  wdat_i,
   input  logic [SLOTS-1:0]         wmask_i,
   input  logic [PTR_W-1:0]         ptr_i,
   output logic [SLOTS*DATA_W-1:0]  taps_o
);
   localparam int DEPTH = 1 << PTR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) begin
         for (int k = 0; k < SLOTS; k++) begin
            if (wmask_i[k]) mem[top_i - PTR_W'(k + 1)] <= wdat_i[k*DATA_W +: DATA_W];
         end
      end
   end

   for (genvar k = 0; k < SLOTS; k++) begin : g_tap
      assign taps_o[k*DATA_W +: DATA_W] = mem[ptr_i - PTR_W'(k + 1)];
   end
endmodule

// File: rtl/dual_byte_stack.sv
module dual_byte_stack #(
   parameter int PTR_W  = 8,
   parameter int DATA_W = 8,
   parameter int ITEMS  = 3,
   parameter int POP_W  = 3,
   parameter int NET_W  = 4,
   parameter int CNT_W  = $clog2(ITEMS + 1)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       op_valid,
   input  logic                       op_rsel,
   input  logic                       op_keep,
   input  logic                       op_flip,
   input  logic [POP_W-1:0]           op_pop,
   input  logic [NET_W-1:0]           op_net,
   input  logic                       wr_word,
   input  logic [CNT_W-1:0]           wr_cnt,
   input  logic [ITEMS*2*DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]          tap_t,
   output logic [DATA_W-1:0]          tap_n,
   output logic [DATA_W-1:0]          tap_l,
   output logic [2*DATA_W-1:0]        tap_t2,
   output logic [2*DATA_W-1:0]        tap_n2,
   output logic [2*DATA_W-1:0]        tap_l2,
   output logic [PTR_W-1:0]           wst_ptr,
   output logic [PTR_W-1:0]           rst_ptr,
   output logic                       fault_valid,
   output logic [1:0]                 fault_code
);
   import dbs_pkg::*;

   localparam int SLOTS = 2 * ITEMS;
   localparam int NB_W  = CNT_W + 1;

   if (PTR_W < 3) begin : g_bad_ptr
      $error("dual_byte_stack: PTR_W must be at least 3");
   end
   if (ITEMS < 3) begin : g_bad_items
      $error("dual_byte_stack: ITEMS must be at least 3 to feed the taps");
   end
   if (NET_W < NB_W + 1) begin : g_bad_net
      $error("dual_byte_stack: NET_W too narrow for the push count");
   end

   logic [PTR_W-1:0]        ptr_q [NUM_STACKS];
   logic                    src_sel, dst_sel;
   logic [PTR_W-1:0]        src_next, dst_next, top_wr;
   logic                    src_under, src_over, dst_under, dst_over;
   logic [SLOTS*DATA_W-1:0] slots;
   logic [SLOTS-1:0]        smask;
   logic [NB_W-1:0]         nbytes;
   fault_e                  fault_now;
   logic                    commit;
   logic [SLOTS*DATA_W-1:0] taps_b [NUM_STACKS];
   logic [SLOTS*DATA_W-1:0] taps_sel;

   assign src_sel = op_rsel;
   assign dst_sel = op_rsel ^ op_flip;

   dbs_pack #(.DATA_W(DATA_W), .ITEMS(ITEMS), .CNT_W(CNT_W), .NB_W(NB_W)) u_pack (
      .word_i   (wr_word),
      .cnt_i    (wr_cnt),
      .items_i  (wr_data),
      .slots_o  (slots),
      .mask_o   (smask),
      .nbytes_o (nbytes)
   );

   dbs_bounds #(.PTR_W(PTR_W), .POP_W(POP_W), .NET_W(NET_W)) u_src_chk (
      .ptr_i   (ptr_q[src_sel]),
      .take_i  (op_pop),
      .keep_i  (op_keep),
      .delta_i (op_net),
      .next_o  (src_next),
      .under_o (src_under),
      .over_o  (src_over)
   );

   dbs_bounds #(.PTR_W(PTR_W), .POP_W(POP_W), .NET_W(NET_W)) u_dst_chk (
      .ptr_i   (ptr_q[dst_sel]),
      .take_i  ('0),
      .keep_i  (1'b0),
      .delta_i (NET_W'(nbytes)),
      .next_o  (dst_next),
      .under_o (dst_under),
      .over_o  (dst_over)
   );

   always_comb begin
      if (src_under)
         fault_now = FLT_UNDER;
      else if (src_over || (op_flip && (dst_over || dst_under)))
         fault_now = FLT_OVER;
      else
         fault_now = FLT_NONE;
   end

   assign commit = op_valid && (fault_now == FLT_NONE);
   assign top_wr = op_flip ? dst_next : src_next;

   for (genvar b = 0; b < NUM_STACKS; b++) begin : g_bank
      logic we_b;
      assign we_b = commit && (dst_sel == 1'(b));
      dbs_bank #(.PTR_W(PTR_W), .DATA_W(DATA_W), .SLOTS(SLOTS)) u_bank (
         .clk     (clk),
         .we_i    (we_b),
         .top_i   (top_wr),
         .wdat_i  (slots),
         .wmask_i (smask),
         .ptr_i   (ptr_q[b]),
         .taps_o  (taps_b[b])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int b = 0; b < NUM_STACKS; b++) ptr_q[b] <= '0;
      end else if (commit) begin
         ptr_q[src_sel] <= src_next;
         if (op_flip) ptr_q[dst_sel] <= dst_next;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         fault_valid <= 1'b0;
         fault_code  <= FLT_NONE;
      end else begin
         fault_valid <= op_valid && (fault_now != FLT_NONE);
         fault_code  <= op_valid ? fault_now : FLT_NONE;
      end
   end

   assign taps_sel = taps_b[op_rsel];
   assign tap_t    = taps_sel[0*DATA_W +: DATA_W];
   assign tap_n    = taps_sel[1*DATA_W +: DATA_W];
   assign tap_l    = taps_sel[2*DATA_W +: DATA_W];
   assign tap_t2   = {taps_sel[1*DATA_W +: DATA_W], taps_sel[0*DATA_W +: DATA_W]};
   assign tap_n2   = {taps_sel[3*DATA_W +: DATA_W], taps_sel[2*DATA_W +: DATA_W]};
   assign tap_l2   = {taps_sel[5*DATA_W +: DATA_W], taps_sel[4*DATA_W +: DATA_W]};
   assign wst_ptr  = ptr_q[0];
   assign rst_ptr  = ptr_q[1];
endmodule

// File: rtl/dual_byte_stack_chk.sv
module dual_byte_stack_chk #(
   parameter int PTR_W = 8,
   parameter int POP_W = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             op_valid,
   input logic             op_rsel,
   input logic             op_flip,
   input logic [POP_W-1:0] op_pop,
   input logic [PTR_W-1:0] wst_ptr,
   input logic [PTR_W-1:0] rst_ptr,
   input logic             fault_valid,
   input logic [1:0]       fault_code
);
   localparam logic [PTR_W-1:0] LIMIT = PTR_W'((1 << PTR_W) - 2);

   AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (wst_ptr == '0 && rst_ptr == '0 && !fault_valid)); // R1
   AST_UNDERFLOW_CODE: assert property (@(posedge clk) disable iff (rst)
      (op_valid && ({{(PTR_W){1'b0}}, op_pop} > {{(POP_W){1'b0}}, (op_rsel ? rst_ptr : wst_ptr)}))
      |=> (fault_valid && fault_code == 2'd1)); // R5
   AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (rst)
      fault_valid |-> ($stable(wst_ptr) && $stable(rst_ptr))); // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (wst_ptr <= LIMIT && rst_ptr <= LIMIT)); // R11
   AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !op_flip && !op_rsel) |=> $stable(rst_ptr)); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> ($stable(wst_ptr) && $stable(rst_ptr) && !fault_valid)); // R12
   AST_CODE_VALID: assert property (@(posedge clk) disable iff (rst)
      fault_valid |-> (fault_code == 2'd1 || fault_code == 2'd2)); // R12
endmodule

bind dual_byte_stack dual_byte_stack_chk #(.PTR_W(PTR_W), .POP_W(POP_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .op_valid    (op_valid),
   .op_rsel     (op_rsel),
   .op_flip     (op_flip),
   .op_pop      (op_pop),
   .wst_ptr     (wst_ptr),
   .rst_ptr     (rst_ptr),
   .fault_valid (fault_valid),
   .fault_code  (fault_code)
);

// File: tb/dual_byte_stack_test.sv
`timescale 1ns/1ps
module dual_byte_stack_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        op_valid = 1'b0, op_rsel = 1'b0, op_keep = 1'b0, op_flip = 1'b0;
   logic [2:0]  op_pop = '0;
   logic [3:0]  op_net = '0;
   logic        wr_word = 1'b0;
   logic [1:0]  wr_cnt = '0;
   logic [47:0] wr_data = '0;
   logic [7:0]  tap_t, tap_n, tap_l, wst_ptr, rst_ptr;
   logic [15:0] tap_t2, tap_n2, tap_l2;
   logic        fault_valid;
   logic [1:0]  fault_code;

   int checks = 0, fails = 0, cycles = 0;
   logic [7:0] mdl [2][256];
   bit         mval [2][256];
   int         mptr [2];
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   dual_byte_stack uut (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_rsel(op_rsel), .op_keep(op_keep),
      .op_flip(op_flip), .op_pop(op_pop), .op_net(op_net), .wr_word(wr_word),
      .wr_cnt(wr_cnt), .wr_data(wr_data), .tap_t(tap_t), .tap_n(tap_n), .tap_l(tap_l),
      .tap_t2(tap_t2), .tap_n2(tap_n2), .tap_l2(tap_l2), .wst_ptr(wst_ptr),
      .rst_ptr(rst_ptr), .fault_valid(fault_valid), .fault_code(fault_code)
   );

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
         finish_run();
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] nxt();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr;
   endfunction

   // Apply one operation and compare fault and pointers with the model.
   task automatic op(int s, bit keep, bit flip, int pop, int net, bit word, int cnt,
                     logic [47:0] data, string req);
      int d, rs, rd, top, code, ebytes;
      @(negedge clk);
      op_valid = 1'b1; op_rsel = s[0]; op_keep = keep; op_flip = flip;
      op_pop = 3'(pop); op_net = 4'(net); wr_word = word; wr_cnt = 2'(cnt); wr_data = data;
      d = flip ? 1 - s : s;
      rs = mptr[s] + (keep ? pop : 0) + net;
      rd = mptr[d];
      code = 0;
      ebytes = word ? 2 * cnt : cnt;
      if (pop > mptr[s]) code = 1;
      else if (rs > 254) code = 2;
      else if (flip) begin
         rd = mptr[d] + ebytes;
         if (rd > 254) code = 2;
      end
      @(posedge clk); #1;
      chk({req, " fault_valid"}, 32'(fault_valid), 32'(code != 0));
      chk({req, " fault_code"}, 32'(fault_code), 32'(code));
      if (code == 0) begin
         mptr[s] = rs;
         if (flip) mptr[d] = rd;
         top = flip ? rd : rs;
         for (int i = 0; i < cnt; i++) begin
            if (word) begin
               mdl[d][(top - 1 - 2*i) & 255] = data[16*i +: 8];
               mdl[d][(top - 2 - 2*i) & 255] = data[16*i+8 +: 8];
               mval[d][(top - 1 - 2*i) & 255] = 1'b1;
               mval[d][(top - 2 - 2*i) & 255] = 1'b1;
            end else begin
               mdl[d][(top - 1 - i) & 255] = data[16*i +: 8];
               mval[d][(top - 1 - i) & 255] = 1'b1;
            end
         end
      end
      chk({req, " wst_ptr"}, 32'(wst_ptr), 32'(mptr[0]));
      chk({req, " rst_ptr"}, 32'(rst_ptr), 32'(mptr[1]));
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   // Compare the taps of both stacks with the model (R9), one idle cycle each.
   task automatic check_taps(string req);
      logic [7:0] act [6];
      for (int s = 0; s < 2; s++) begin
         @(negedge clk);
         op_rsel = s[0];
         #1;
         chk({req, " R12 idle strobe"}, 32'(fault_valid), 32'd0);
         act[0] = tap_t; act[1] = tap_n; act[2] = tap_l;
         chk("R9 word/byte tap agreement t2", 32'(tap_t2), 32'({tap_n, tap_t}));
         act[3] = tap_n2[15:8]; act[4] = tap_l2[7:0]; act[5] = tap_l2[15:8];
         if (tap_n2[7:0] !== tap_l) chk("R9 n2 low byte", 32'(tap_n2[7:0]), 32'(tap_l));
         for (int k = 0; k < 6; k++) begin
            int idx = (mptr[s] - 1 - k) & 255;
            if (k < mptr[s] && mval[s][idx])
               chk({req, " R9 tap byte"}, 32'(act[k]), 32'(mdl[s][idx]));
         end
      end
   endtask

   initial begin
      for (int s = 0; s < 2; s++) begin
         mptr[s] = 0;
         for (int i = 0; i < 256; i++) begin mval[s][i] = 1'b0; mdl[s][i] = '0; end
      end
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset wst_ptr", 32'(wst_ptr), 0);
      chk("R1 reset rst_ptr", 32'(rst_ptr), 0);
      chk("R1 reset fault", 32'(fault_valid), 0);
      @(negedge clk); rst = 1'b0;

      // Underflow sweep on both stacks (R5, R2).
      for (int s = 0; s < 2; s++) begin
         for (int p = 0; p <= 6; p++) begin
            for (int pop = 0; pop < 8; pop++)
               op(s, 0, 0, pop, 0, 0, 0, '0, "R5 underflow sweep");
            op(s, 0, 0, 0, 1, 0, 1, 48'(8'h10 * s + p + 1), "R7 single byte push");
         end
         check_taps("R2 after sweep");
      end

      // Non-keep and keep arithmetic-style operations (R3, R4).
      for (int pop = 0; pop <= 4; pop++) begin
         op(0, 0, 0, pop, 1 - pop, 0, 1, 48'(8'hA0 + pop), "R3 consume/produce");
         check_taps("R3");
         op(0, 1, 0, pop, 1 - pop, 0, 1, 48'(8'hB0 + pop), "R4 keep consume/produce");
         check_taps("R4");
      end

      // Byte and word pushes of 1..3 items (R7, R8).
      for (int cnt = 1; cnt <= 3; cnt++) begin
         op(1, 0, 0, 0, cnt, 0, cnt, 48'h0000_C3C3_C2C2_C1C1 + 48'(cnt), "R7 byte push");
         check_taps("R7");
         op(1, 0, 0, 0, 2 * cnt, 1, cnt, 48'h3344_5566_7788 + 48'(cnt << 4), "R8 word push");
         check_taps("R8");
      end

      // Fill the return stack to the limit, sweeping net near the top (R6).
      while (mptr[1] < 242) op(1, 0, 0, 0, 6, 1, 3, 48'(nxt()), "R6 fill");
      while (mptr[1] < 254) begin
         for (int net = 0; net < 8; net++) op(1, 0, 0, 0, net, 0, 0, '0, "R6 overflow sweep");
         op(1, 1, 0, 2, 0, 0, 0, '0, "R6 keep overflow");
         op(1, 0, 0, 0, 1, 0, 1, 48'(nxt()), "R6 step");
      end
      check_taps("R6");

      // Flip toward the full return stack must fault on the destination (R11).
      op(0, 0, 1, 1, -1, 1, 1, 48'h1234, "R11 flip into full stack");
      op(0, 0, 1, 0, 0, 0, 1, 48'h55, "R11 flip byte into full stack");
      op(1, 0, 1, 2, -2, 0, 0, '0, "R10 flip with no push");
      check_taps("R11");

      // Drain and flip in both directions (R10).
      while (mptr[1] > 20) op(1, 0, 0, 6, -6, 0, 0, '0, "R3 drain");
      op(0, 0, 1, 1, -1, 1, 1, 48'hBEEF, "R10 call-like flip");
      op(1, 0, 1, 2, -2, 1, 1, 48'hCAFE, "R10 stash word back");
      op(0, 1, 1, 1, -1, 0, 1, 48'h77, "R10 keep flip");
      check_taps("R10");

      // Pseudo-random mix of every field (all requirements).
      for (int n = 0; n < 600; n++) begin
         logic [15:0] r = nxt();
         int pop = int'(r[4:2]);
         int net = int'(r[15:12]) % (pop + 4) - pop;
         if (net > 7) net = 7;
         op(int'(r[0]), r[1], r[5], pop, net, r[6], int'(r[8:7]),
            {nxt(), nxt(), nxt()}, "R3 R4 R10 random mix");
         if (n % 8 == 0) check_taps("R9 random");
      end

      // Idle cycles must change nothing (R12).
      repeat (3) @(posedge clk);
      #1;
      chk("R12 idle wst_ptr", 32'(wst_ptr), 32'(mptr[0]));
      chk("R12 idle rst_ptr", 32'(rst_ptr), 32'(mptr[1]));
      check_taps("R12");
      finish_run();
   end
endmodule